// File: doc/BRIEF.md
# Segmented-Paged Address Translator

This block turns a 20-bit logical address into a 20-bit physical address. The logical address carries a segment number, a page number and a word offset. A segment table gives each segment a page-table base. That base plus the page number selects a page-table entry. The entry holds a 12-bit block number and a 2-bit access-rights code. The physical address is the block number joined to the unchanged word offset.

A small fully associative translation buffer caches recent (segment, page) → (block, rights) results. A request that hits in the buffer is answered on the next cycle. A miss walks the two tables in two cycles and then fills the buffer, choosing the entry to replace in round-robin order. Every response is checked against the access kind and the privilege of the requester. A denied access raises a fault and issues no address. Both tables are loaded through synchronous write ports. A single input flushes the buffer.

Top module: `addrXlate`

## Requirements
- R1: The logical address is split as segment = bits [19:16], page = bits [15:8] and word = bits [7:0]. The physical address is the block number in bits [19:8] and the word offset in bits [7:0].
- R2: On a buffer miss, the page-table index is (segment-table entry of the segment + page) modulo 256. The block number and the rights come from that page-table entry.
- R3: The word offset reaches the physical address unchanged on every response that does not fault.
- R4: A request is accepted on a clock edge where reqValid is high and busy is low. On a buffer hit, respValid pulses one cycle after acceptance with respHit = 1. On a miss, respValid pulses three cycles after acceptance with respHit = 0, and the translation is loaded into the buffer whether or not it faults.
- R5: reqKind is encoded 00 = data read, 01 = data write, 10 = instruction fetch; 11 is handled like a fetch. Rights are encoded 00 = read/write, 01 = read only, 10 = execute only, 11 = system only. A write to a read-only page faults. A read or write to an execute-only page faults. A request with reqUser = 1 to a system-only page faults. On a fault, respFault = 1 and respPhysAddr = 0. A fetch from a read-only page is allowed.
- R6: Buffer fills replace entries in round-robin order, starting at entry 0 after reset. The buffer has four entries by default.
- R7: When invalidate is high, every buffer entry is cleared at the next edge, and a lookup made in the same cycle misses.
- R8: busy is high from acceptance of a missing request until its response. A request presented while busy is ignored and produces no response.
- R9: Segment-table and page-table entries are written on the clock edge where their write enable is high.
- R10: After reset, busy and respValid are low and the buffer holds no valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqLogAddr | input | 20 | Logical address (segment, page, word) |
| reqKind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| reqUser | input | 1 | 1 = request made in user mode |
| invalidate | input | 1 | Clear all translation buffer entries |
| segWrEn | input | 1 | Segment table write enable |
| segWrIdx | input | 4 | Segment table entry to write |
| segWrBase | input | 8 | Page-table base for that segment |
| pgWrEn | input | 1 | Page table write enable |
| pgWrIdx | input | 8 | Page table entry to write |
| pgWrBlock | input | 12 | Block number for that entry |
| pgWrRights | input | 2 | Access rights for that entry |
| busy | output | 1 | Table walk in progress |
| respValid | output | 1 | One-cycle response strobe |
| respPhysAddr | output | 20 | Physical address, zero on fault |
| respFault | output | 1 | Protection fault |
| respHit | output | 1 | Response came from the translation buffer |

## Verification
The bench goes after an index sum that crosses 0xFF. A design that carries instead of wrapping would read the wrong page entry and return a wrong block. It checks the rights combinations one by one, including a fetch from a read-only page, where a design that over-restricts would fault. It also checks a faulting miss followed by a hit on the same page, which exposes a design that skips the fill on a fault. A long sequence of misses shows the round-robin victim order: a design with the wrong order would hit or miss on the wrong later request. Further tests cover a flush after a page-table rewrite, which would return the stale block if entries survived, and a request made during a walk, which must draw no second response.

// File: rtl/xlatePkg.sv
package xlatePkg;

  localparam int RIGHTS_W = 2;

  localparam logic [1:0] RIGHTS_RW  = 2'b00;
  localparam logic [1:0] RIGHTS_RO  = 2'b01;
  localparam logic [1:0] RIGHTS_XO  = 2'b10;
  localparam logic [1:0] RIGHTS_SYS = 2'b11;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  typedef struct packed {
    logic acceptReq;
    logic latchSeg;
    logic finishWalk;
    logic respondHit;
  } ctrlStrobesT;

  function automatic logic accessDenied(input logic [1:0] rights,
                                        input logic [1:0] kind,
                                        input logic user);
    logic isData;
    isData = (kind == ACC_READ) || (kind == ACC_WRITE);
    return ((kind == ACC_WRITE) && (rights == RIGHTS_RO)) ||
           (isData && (rights == RIGHTS_XO)) ||
           (user && (rights == RIGHTS_SYS));
  endfunction

endpackage

// File: rtl/xlateBuffer.sv
module xlateBuffer
  import xlatePkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int BLOCK_W = 12,
  parameter int ENTRIES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEG_W-1:0]    lookSeg,
  input  logic [PAGE_W-1:0]   lookPage,
  input  logic                invalidate,
  input  logic                fillEn,
  input  logic [SEG_W-1:0]    fillSeg,
  input  logic [PAGE_W-1:0]   fillPage,
  input  logic [BLOCK_W-1:0]  fillBlock,
  input  logic [RIGHTS_W-1:0] fillRights,
  output logic                hit,
  output logic [BLOCK_W-1:0]  hitBlock,
  output logic [RIGHTS_W-1:0] hitRights
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]  matchVec;
  logic [BLOCK_W-1:0]  blockArr  [ENTRIES];
  logic [RIGHTS_W-1:0] rightsArr [ENTRIES];
  logic [PTR_W-1:0]    victimPtr;
  logic                doFill;

  assign doFill = fillEn && !invalidate;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : gEntry
    logic                entValid;
    logic [SEG_W-1:0]    entSeg;
    logic [PAGE_W-1:0]   entPage;
    logic [BLOCK_W-1:0]  entBlock;
    logic [RIGHTS_W-1:0] entRights;
    logic                isVictim;

    assign isVictim = doFill && (victimPtr == PTR_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN || invalidate) begin
        entValid <= 1'b0;
      end else if (isVictim) begin
        entValid <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (isVictim) begin
        entSeg    <= fillSeg;
        entPage   <= fillPage;
        entBlock  <= fillBlock;
        entRights <= fillRights;
      end
    end

    assign matchVec[gi]  = entValid && (entSeg == lookSeg) && (entPage == lookPage);
    assign blockArr[gi]  = entBlock;
    assign rightsArr[gi] = entRights;
  end

  always_comb begin
    hitBlock  = '0;
    hitRights = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitBlock  = blockArr[i];
        hitRights = rightsArr[i];
      end
    end
  end

  assign hit = (|matchVec) && !invalidate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimPtr <= '0;
    end else if (doFill) begin
      victimPtr <= (victimPtr == LAST_PTR) ? '0 : victimPtr + 1'b1;
    end
  end

endmodule

// File: rtl/xlateDatapath.sv
module xlateDatapath
  import xlatePkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int WORD_W  = 8,
  parameter int BLOCK_W = 12,
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobesT                strobes,
  input  logic [SEG_W+PAGE_W+WORD_W-1:0] reqLogAddr,
  input  logic [1:0]                 reqKind,
  input  logic                       reqUser,
  input  logic                       invalidate,
  input  logic                       segWrEn,
  input  logic [SEG_W-1:0]           segWrIdx,
  input  logic [PAGE_W-1:0]          segWrBase,
  input  logic                       pgWrEn,
  input  logic [PAGE_W-1:0]          pgWrIdx,
  input  logic [BLOCK_W-1:0]         pgWrBlock,
  input  logic [RIGHTS_W-1:0]        pgWrRights,
  output logic                       bufHit,
  output logic                       respValid,
  output logic [BLOCK_W+WORD_W-1:0]  respPhysAddr,
  output logic                       respFault,
  output logic                       respHit
);

  localparam int SEG_ENTRIES  = 2 ** SEG_W;
  localparam int PAGE_ENTRIES = 2 ** PAGE_W;
  localparam int PAGE_LSB     = WORD_W;
  localparam int SEG_LSB      = WORD_W + PAGE_W;

  logic [PAGE_W-1:0]   segTable   [SEG_ENTRIES];
  logic [BLOCK_W-1:0]  pgBlockTab [PAGE_ENTRIES];
  logic [RIGHTS_W-1:0] pgRightsTab[PAGE_ENTRIES];

  logic [SEG_W-1:0]  liveSeg;
  logic [PAGE_W-1:0] livePage;
  logic [WORD_W-1:0] liveWord;

  logic [SEG_W-1:0]  capSeg;
  logic [PAGE_W-1:0] capPage;
  logic [WORD_W-1:0] capWord;
  logic [1:0]        capKind;
  logic              capUser;
  logic [PAGE_W-1:0] capBase;

  logic [PAGE_W-1:0]   walkIdx;
  logic [BLOCK_W-1:0]  walkBlock;
  logic [RIGHTS_W-1:0] walkRights;
  logic [BLOCK_W-1:0]  hitBlock;
  logic [RIGHTS_W-1:0] hitRights;
  logic                hitDenied;
  logic                walkDenied;

  assign liveSeg  = reqLogAddr[SEG_LSB +: SEG_W];
  assign livePage = reqLogAddr[PAGE_LSB +: PAGE_W];
  assign liveWord = reqLogAddr[0 +: WORD_W];

  always_ff @(posedge clk) begin
    if (segWrEn) begin
      segTable[segWrIdx] <= segWrBase;
    end
  end

  always_ff @(posedge clk) begin
    if (pgWrEn) begin
      pgBlockTab[pgWrIdx]  <= pgWrBlock;
      pgRightsTab[pgWrIdx] <= pgWrRights;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.acceptReq) begin
      capSeg  <= liveSeg;
      capPage <= livePage;
      capWord <= liveWord;
      capKind <= reqKind;
      capUser <= reqUser;
    end
    if (strobes.latchSeg) begin
      capBase <= segTable[capSeg];
    end
  end

  assign walkIdx    = capBase + capPage;
  assign walkBlock  = pgBlockTab[walkIdx];
  assign walkRights = pgRightsTab[walkIdx];

  xlateBuffer #(
    .SEG_W  (SEG_W),
    .PAGE_W (PAGE_W),
    .BLOCK_W(BLOCK_W),
    .ENTRIES(ENTRIES)
  ) uBuffer (
    .clk       (clk),
    .rstN      (rstN),
    .lookSeg   (liveSeg),
    .lookPage  (livePage),
    .invalidate(invalidate),
    .fillEn    (strobes.finishWalk),
    .fillSeg   (capSeg),
    .fillPage  (capPage),
    .fillBlock (walkBlock),
    .fillRights(walkRights),
    .hit       (bufHit),
    .hitBlock  (hitBlock),
    .hitRights (hitRights)
  );

  assign hitDenied  = accessDenied(hitRights, reqKind, reqUser);
  assign walkDenied = accessDenied(walkRights, capKind, capUser);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      respPhysAddr <= '0;
      respFault    <= 1'b0;
      respHit      <= 1'b0;
    end else begin
      respValid <= strobes.respondHit || strobes.finishWalk;
      if (strobes.respondHit) begin
        respHit      <= 1'b1;
        respFault    <= hitDenied;
        respPhysAddr <= hitDenied ? '0 : {hitBlock, liveWord};
      end else if (strobes.finishWalk) begin
        respHit      <= 1'b0;
        respFault    <= walkDenied;
        respPhysAddr <= walkDenied ? '0 : {walkBlock, capWord};
      end
    end
  end

endmodule

// File: rtl/xlateCtrl.sv
module xlateCtrl
  import xlatePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        bufHit,
  output ctrlStrobesT strobes,
  output logic        busy
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEG  = 2'd1,
    ST_PAGE = 2'd2
  } walkStateT;

  walkStateT state;
  walkStateT stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (bufHit) begin
            strobes.respondHit = 1'b1;
          end else begin
            strobes.acceptReq = 1'b1;
            stateNext         = ST_SEG;
          end
        end
      end
      ST_SEG: begin
        strobes.latchSeg = 1'b1;
        stateNext        = ST_PAGE;
      end
      ST_PAGE: begin
        strobes.finishWalk = 1'b1;
        stateNext          = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/addrXlate.sv
module addrXlate
  import xlatePkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int WORD_W  = 8,
  parameter int BLOCK_W = 12,
  parameter int ENTRIES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [SEG_W+PAGE_W+WORD_W-1:0] reqLogAddr,
  input  logic [1:0]                    reqKind,
  input  logic                          reqUser,
  input  logic                          invalidate,
  input  logic                          segWrEn,
  input  logic [SEG_W-1:0]              segWrIdx,
  input  logic [PAGE_W-1:0]             segWrBase,
  input  logic                          pgWrEn,
  input  logic [PAGE_W-1:0]             pgWrIdx,
  input  logic [BLOCK_W-1:0]            pgWrBlock,
  input  logic [1:0]                    pgWrRights,
  output logic                          busy,
  output logic                          respValid,
  output logic [BLOCK_W+WORD_W-1:0]     respPhysAddr,
  output logic                          respFault,
  output logic                          respHit
);

  ctrlStrobesT strobes;
  logic        bufHit;

  xlateCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .bufHit  (bufHit),
    .strobes (strobes),
    .busy    (busy)
  );

  xlateDatapath #(
    .SEG_W  (SEG_W),
    .PAGE_W (PAGE_W),
    .WORD_W (WORD_W),
    .BLOCK_W(BLOCK_W),
    .ENTRIES(ENTRIES)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqLogAddr  (reqLogAddr),
    .reqKind     (reqKind),
    .reqUser     (reqUser),
    .invalidate  (invalidate),
    .segWrEn     (segWrEn),
    .segWrIdx    (segWrIdx),
    .segWrBase   (segWrBase),
    .pgWrEn      (pgWrEn),
    .pgWrIdx     (pgWrIdx),
    .pgWrBlock   (pgWrBlock),
    .pgWrRights  (pgWrRights),
    .bufHit      (bufHit),
    .respValid   (respValid),
    .respPhysAddr(respPhysAddr),
    .respFault   (respFault),
    .respHit     (respHit)
  );

endmodule

// File: rtl/addrXlateChk.sv
module addrXlateChk #(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int WORD_W  = 8,
  parameter int BLOCK_W = 12
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           reqValid,
  input logic [SEG_W+PAGE_W+WORD_W-1:0] reqLogAddr,
  input logic                           invalidate,
  input logic                           busy,
  input logic                           respValid,
  input logic [BLOCK_W+WORD_W-1:0]      respPhysAddr,
  input logic                           respFault,
  input logic                           respHit
);

  // R5: a faulting response carries no address
  p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> (respPhysAddr == '0));

  // R3: a hit response keeps the word offset of the request it answers
  p_word_passthru_r3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit && !respFault) |->
      (respPhysAddr[WORD_W-1:0] == $past(reqLogAddr[WORD_W-1:0])));

  // R4: every walk ends with a miss response
  p_walk_ends_resp_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (respValid && !respHit));

  // R2: a walk spans at least the segment and the page table cycles
  p_walk_two_steps_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  // R7: a lookup made while invalidating must miss and start a walk
  p_flush_forces_walk_r7: assert property (@(posedge clk) disable iff (!rstN)
    (invalidate && reqValid && !busy) |=> busy);

  // R8: a request seen while busy never yields a hit response
  p_busy_ignores_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> !(respValid && respHit));

endmodule

bind addrXlate addrXlateChk #(
  .SEG_W  (SEG_W),
  .PAGE_W (PAGE_W),
  .WORD_W (WORD_W),
  .BLOCK_W(BLOCK_W)
) uChk (.*);

// File: tb/addrXlate_test.sv
`timescale 1ns/1ps
module addrXlate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [19:0] reqLogAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic        invalidate = 1'b0;
  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [7:0]  segWrBase = '0;
  logic        pgWrEn = 1'b0;
  logic [7:0]  pgWrIdx = '0;
  logic [11:0] pgWrBlock = '0;
  logic [1:0]  pgWrRights = '0;
  logic        busy;
  logic        respValid;
  logic [19:0] respPhysAddr;
  logic        respFault;
  logic        respHit;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addrXlate uut (.*);

  // vector: logical address, kind, user, expected physical, fault, hit
  localparam int NVEC = 12;
  localparam logic [44:0] VECS [NVEC] = '{
    {20'h6027E, 2'd0, 1'b0, 20'h0197E, 1'b0, 1'b0}, // R2 R1 walk to block 0x019
    {20'h60210, 2'd1, 1'b0, 20'h01910, 1'b0, 1'b1}, // R4 hit, write to rw page
    {20'h60305, 2'd1, 1'b0, 20'h00000, 1'b1, 1'b0}, // R5 write to read-only
    {20'h603AA, 2'd0, 1'b0, 20'h053AA, 1'b0, 1'b1}, // R4 faulted miss was filled
    {20'h60401, 2'd0, 1'b0, 20'h00000, 1'b1, 1'b0}, // R5 read of execute-only
    {20'h60402, 2'd2, 1'b0, 20'hA6102, 1'b0, 1'b1}, // R5 fetch of execute-only
    {20'h20355, 2'd0, 1'b1, 20'h00000, 1'b1, 1'b0}, // R5 user to system, R2 wrap
    {20'h20356, 2'd0, 1'b0, 20'h7C156, 1'b0, 1'b1}, // R5 supervisor to system
    {20'h60130, 2'd0, 1'b0, 20'h2B430, 1'b0, 1'b0}, // R6 replaces entry 0
    {20'h6027E, 2'd0, 1'b0, 20'h0197E, 1'b0, 1'b0}, // R6 evicted, refill entry 1
    {20'h60300, 2'd2, 1'b0, 20'h05300, 1'b0, 1'b0}, // R6 evicted, R5 fetch of read-only
    {20'h20300, 2'd2, 1'b0, 20'h7C100, 1'b0, 1'b1}  // R6 entry 3 survived
  };

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeSeg(input logic [3:0] idx, input logic [7:0] base);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = idx; segWrBase = base;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic writePage(input logic [7:0] idx, input logic [11:0] blk, input logic [1:0] rts);
    @(negedge clk);
    pgWrEn = 1'b1; pgWrIdx = idx; pgWrBlock = blk; pgWrRights = rts;
    @(negedge clk);
    pgWrEn = 1'b0;
  endtask

  task automatic doReq(input logic [19:0] a, input logic [1:0] k, input logic u,
                       input logic inval, output int lat);
    @(negedge clk);
    reqLogAddr = a; reqKind = k; reqUser = u; reqValid = 1'b1; invalidate = inval;
    @(negedge clk);
    reqValid = 1'b0; invalidate = 1'b0;
    lat = 1;
    while (!respValid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    int lat;
    int pulses;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    checkVal("R10 busy after reset", 32'(busy), 32'd0);
    checkVal("R10 respValid after reset", 32'(respValid), 32'd0);

    // R9 table loading
    writeSeg(4'h6, 8'h35);
    writeSeg(4'h2, 8'hFE);
    writePage(8'h36, 12'h2B4, 2'b00);
    writePage(8'h37, 12'h019, 2'b00);
    writePage(8'h38, 12'h053, 2'b01);
    writePage(8'h39, 12'hA61, 2'b10);
    writePage(8'h01, 12'h7C1, 2'b11);

    for (int i = 0; i < NVEC; i++) begin
      logic [44:0] v;
      v = VECS[i];
      doReq(v[44:25], v[24:23], v[22], 1'b0, lat);
      checkVal($sformatf("R4 vec%0d respValid", i), 32'(respValid), 32'd1);
      checkVal($sformatf("R1 vec%0d phys", i), 32'(respPhysAddr), 32'(v[21:2]));
      checkVal($sformatf("R5 vec%0d fault", i), 32'(respFault), 32'(v[1]));
      checkVal($sformatf("R6 vec%0d hit", i), 32'(respHit), 32'(v[0]));
      checkVal($sformatf("R4 vec%0d latency", i), 32'(lat), v[0] ? 32'd1 : 32'd3);
    end

    // R7 flush after rewriting a cached page entry
    writePage(8'h01, 12'h111, 2'b00);
    doReq(20'h20377, 2'd0, 1'b1, 1'b1, lat);
    checkVal("R7 flushed lookup misses", 32'(respHit), 32'd0);
    checkVal("R7 new block after flush", 32'(respPhysAddr), 32'h11177);
    checkVal("R9 rewritten rights apply", 32'(respFault), 32'd0);
    doReq(20'h6027E, 2'd0, 1'b0, 1'b0, lat);
    checkVal("R7 old entry gone", 32'(respHit), 32'd0);

    // R8 request during a walk is ignored
    @(negedge clk);
    reqLogAddr = 20'h60123; reqKind = 2'd0; reqUser = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    checkVal("R8 busy during walk", 32'(busy), 32'd1);
    reqLogAddr = 20'h20344;
    @(negedge clk);
    reqValid = 1'b0;
    pulses = 0;
    for (int c = 0; c < 6; c++) begin
      if (respValid) begin
        pulses++;
        checkVal("R8 response is first request", 32'(respPhysAddr), 32'h2B423);
      end
      @(negedge clk);
    end
    checkVal("R8 single response", 32'(pulses), 32'd1);
    checkVal("R8 idle after walk", 32'(busy), 32'd0);

    // R3 word offset extremes
    doReq(20'h602FF, 2'd0, 1'b0, 1'b0, lat);
    checkVal("R3 word 0xFF", 32'(respPhysAddr), 32'h019FF);
    doReq(20'h60200, 2'd1, 1'b0, 1'b0, lat);
    checkVal("R3 word 0x00", 32'(respPhysAddr), 32'h01900);

    done = 1'b1;
    finishRun();
  end

endmodule